// File: doc/BRIEF.md
# Adaptive Dead-Time Search Controller

This block searches for the shortest dead time a half-bridge leg can use before shoot-through current starts. It starts from a long, safe dead time and shortens it by a fixed step between measurements. Each measurement follows the same sequence. The block resets an external peak-hold detector through a discharge switch. It then releases the switch and waits for the detector to capture the switching overshoot. Last, it asks an ADC for a conversion through a request/ready handshake.

While the dead time falls, the overshoot from diode reverse recovery also falls, so the captured peak is expected to fall. Once cross conduction begins, the peak rises again. The block keeps the lowest peak seen so far. When a new sample exceeds that minimum by more than a set margin, it stops, moves the dead time back up one step, and reports that value. If the dead time reaches a lower floor with no rise seen, the search ends with an error flag set. The code stays at the last value that was measured.

A supervisor pulses the start input and then reads the dead-time code once the one-cycle done pulse appears. One code LSB stands for roughly 10 ns. The defaults therefore begin at 750 ns and step by 50 ns. The timer defaults assume a 100 MHz clock: 300 µs of discharge and 200 µs of settling.

Top module: `dt_search_ctrl`

## Requirements
- R1: After reset, busy, done, ADC request and error are low, the discharge switch is on, and the dead-time code equals START_CODE.
- R2: A start pulse while idle makes busy high on the next cycle and loads START_CODE. A start pulse while busy has no effect on the running search.
- R3: Each measurement holds the discharge switch on for exactly DIS_CYC cycles. It then holds it off for SETTLE_CYC cycles with no ADC request, and raises the ADC request in the next cycle.
- R4: The ADC request stays high until adc_rdy_i is seen. adc_data_i is captured in that cycle.
- R5: The first sample of a search sets the running minimum. A later sample that is not a rise lowers the minimum if it is smaller, and the code then steps down by STEP_CODE.
- R6: A sample is a rise only when it is strictly greater than minimum + RISE_MARGIN. A sample equal to minimum + RISE_MARGIN is not a rise. If a rise and the floor condition occur in the same evaluation, the rise takes priority.
- R7: On a rise, the result is the measured code plus STEP_CODE and the error flag is low.
- R8: When a sample that is not a rise is taken at a code below FLOOR_CODE + STEP_CODE, the search ends with the error flag high. The code stays at that measured value.
- R9: done is high for exactly one cycle at the end of a search. The code and the error flag then stay unchanged until the next accepted start.
- R10: The discharge switch is off only between the end of a discharge and the capture of an ADC sample. It is on whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a search (only while idle) |
| dt_code_o | output | CODE_W | Current or resulting dead-time code |
| discharge_o | output | 1 | Peak-detector discharge switch, 1 = discharging |
| adc_req_o | output | 1 | ADC conversion request |
| adc_rdy_i | input | 1 | ADC result valid |
| adc_data_i | input | ADC_W | ADC result |
| done_o | output | 1 | One-cycle end-of-search pulse |
| busy_o | output | 1 | Search in progress |
| floor_err_o | output | 1 | Search reached the floor with no rise |

## Verification
The collision of concern is a rise detected at the floor code. In that one evaluation, both the back-off rule and the floor-exhaustion rule are true. The bench provokes it by placing the rising sample at the last code allowed. It expects the back-off result, with the code one step above the floor and the error flag low. Over a sweep of rise positions, it also places a sample exactly at the margin against one just above it. This separates a near-rise from a real rise, including at the floor.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DISCH,
    S_SETTLE,
    S_CONV,
    S_EVAL
  } dts_state_e;
endpackage

// File: rtl/dts_timer.sv
module dts_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i || hit_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // window counter never passes its limit (R3)
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> cnt_q <= limit_i);
endmodule

// File: rtl/dts_judge.sv
module dts_judge #(
  parameter int ADC_W       = 12,
  parameter int RISE_MARGIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             eval_i,
  input  logic [ADC_W-1:0] sample_i,
  output logic             rise_o
);
  logic [ADC_W-1:0] min_q;
  logic             have_min_q;

  function automatic logic exceeds(input logic [ADC_W-1:0] s,
                                   input logic [ADC_W-1:0] m);
    return {1'b0, s} > ({1'b0, m} + (ADC_W+1)'(RISE_MARGIN));
  endfunction

  assign rise_o = have_min_q && exceeds(sample_i, min_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q      <= '0;
      have_min_q <= 1'b0;
    end else if (clear_i) begin
      have_min_q <= 1'b0;
    end else if (eval_i && !rise_o) begin
      have_min_q <= 1'b1;
      if (!have_min_q || sample_i < min_q) min_q <= sample_i;
    end
  end

  // the running minimum never grows inside a search (R5)
  p_min_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (have_min_q && !clear_i) |=> min_q <= $past(min_q));
endmodule

// File: rtl/dt_search_ctrl.sv
module dt_search_ctrl #(
  parameter int CODE_W      = 8,
  parameter int START_CODE  = 75,
  parameter int STEP_CODE   = 5,
  parameter int FLOOR_CODE  = 10,
  parameter int ADC_W       = 12,
  parameter int RISE_MARGIN = 8,
  parameter int DIS_CYC     = 30000,
  parameter int SETTLE_CYC  = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [CODE_W-1:0] dt_code_o,
  output logic              discharge_o,
  output logic              adc_req_o,
  input  logic              adc_rdy_i,
  input  logic [ADC_W-1:0]  adc_data_i,
  output logic              done_o,
  output logic              busy_o,
  output logic              floor_err_o
);
  import dts_pkg::*;

  localparam int MAX_WIN = (DIS_CYC > SETTLE_CYC) ? DIS_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);

  dts_state_e        state_q;
  logic [CODE_W-1:0] dt_q;
  logic [ADC_W-1:0]  samp_q;
  logic              done_q, err_q;

  function automatic logic [CODE_W-1:0] step_down(input logic [CODE_W-1:0] c);
    return c - CODE_W'(STEP_CODE);
  endfunction
  function automatic logic [CODE_W-1:0] step_up(input logic [CODE_W-1:0] c);
    return c + CODE_W'(STEP_CODE);
  endfunction
  function automatic logic below_limit(input logic [CODE_W-1:0] c);
    return {1'b0, c} < (CODE_W+1)'(FLOOR_CODE + STEP_CODE);
  endfunction

  // named internal events
  logic start_acc_w, win_run_w, win_hit_w, rise_w, at_floor_w, eval_w;
  logic [CNT_W-1:0] win_lim_w;

  assign start_acc_w = start_i && (state_q == S_IDLE);
  assign win_run_w   = (state_q == S_DISCH) || (state_q == S_SETTLE);
  assign win_lim_w   = (state_q == S_DISCH) ? CNT_W'(DIS_CYC - 1) : CNT_W'(SETTLE_CYC - 1);
  assign eval_w      = (state_q == S_EVAL);
  assign at_floor_w  = below_limit(dt_q);

  dts_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(win_run_w), .limit_i(win_lim_w), .hit_o(win_hit_w)
  );

  dts_judge #(.ADC_W(ADC_W), .RISE_MARGIN(RISE_MARGIN)) u_judge (
    .clk(clk), .rst_n(rst_n), .clear_i(start_acc_w), .eval_i(eval_w),
    .sample_i(samp_q), .rise_o(rise_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dt_q    <= CODE_W'(START_CODE);
      samp_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_acc_w) begin
          dt_q    <= CODE_W'(START_CODE);
          err_q   <= 1'b0;
          state_q <= S_DISCH;
        end
        S_DISCH:  if (win_hit_w) state_q <= S_SETTLE;
        S_SETTLE: if (win_hit_w) state_q <= S_CONV;
        S_CONV: if (adc_rdy_i) begin
          samp_q  <= adc_data_i;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          if (rise_w) begin
            dt_q    <= step_up(dt_q);
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (at_floor_w) begin
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            dt_q    <= step_down(dt_q);
            state_q <= S_DISCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign dt_code_o   = dt_q;
  assign busy_o      = (state_q != S_IDLE);
  assign discharge_o = !((state_q == S_SETTLE) || (state_q == S_CONV));
  assign adc_req_o   = (state_q == S_CONV);
  assign done_o      = done_q;
  assign floor_err_o = err_q;

  // idle always discharges (R10)
  p_dis_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> discharge_o);
  // request only while the detector holds its peak (R10)
  p_req_hold_peak_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req_o |-> !discharge_o);
  // request not dropped before ready (R4)
  p_req_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req_o && !adc_rdy_i) |=> adc_req_o);
  // release of the switch starts a settle window, not a conversion (R3)
  p_settle_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(discharge_o) |-> !adc_req_o);
  // done is a single pulse (R9)
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // result holds while idle (R9)
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(dt_code_o) && $stable(floor_err_o)));
  // error only reported at the floor (R8)
  p_err_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && floor_err_o) |-> below_limit(dt_code_o));
  // code never goes under the floor (R8)
  p_code_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dt_code_o >= CODE_W'(FLOOR_CODE));
endmodule

// File: tb/dt_search_ctrl_tb.sv
module dt_search_ctrl_tb;
  localparam int CODE_W = 8, START = 30, STEP = 5, FLOOR = 10;
  localparam int ADC_W = 8, MARGIN = 2, DIS = 4, SETTLE = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, adc_rdy = 1'b0;
  logic [ADC_W-1:0] adc_data = '0;
  logic [CODE_W-1:0] dt_code;
  logic discharge, adc_req, done, busy, ferr;

  always #5 clk = ~clk;

  dt_search_ctrl #(.CODE_W(CODE_W), .START_CODE(START), .STEP_CODE(STEP),
    .FLOOR_CODE(FLOOR), .ADC_W(ADC_W), .RISE_MARGIN(MARGIN),
    .DIS_CYC(DIS), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dt_code_o(dt_code),
    .discharge_o(discharge), .adc_req_o(adc_req), .adc_rdy_i(adc_rdy),
    .adc_data_i(adc_data), .done_o(done), .busy_o(busy), .floor_err_o(ferr));

  int n_chk = 0, n_fail = 0;
  int samp [0:7];
  int idx = 0, lat_g = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ADC model: answers a request after lat_g extra cycles
  initial begin
    forever begin
      @(negedge clk);
      if (adc_req && !adc_rdy) begin
        repeat (lat_g) @(negedge clk);
        adc_data = ADC_W'(samp[idx]);
        adc_rdy  = 1'b1;
        @(negedge clk);
        adc_rdy  = 1'b0;
        idx++;
      end
    end
  end

  // expected outcome from the requirements
  task automatic model(output int code, output int err, output int nmeas);
    int mn = 0;
    bit have = 1'b0;
    code = START; err = 0; nmeas = 0;
    forever begin
      int s = samp[nmeas];
      nmeas++;
      if (have && s > mn + MARGIN) begin code = code + STEP; err = 0; break; end
      if (!have || s < mn) mn = s;
      have = 1'b1;
      if (code < FLOOR + STEP) begin err = 1; break; end
      code = code - STEP;
    end
  endtask

  task automatic run(input string tag, input int lat, input bit poke, input bit timing);
    int ec, ee, en, c1, c2;
    model(ec, ee, en);
    idx = 0; lat_g = lat;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk({"R2 busy after start ", tag}, busy, 1);
    if (timing) begin
      c1 = 0; c2 = 0;
      while (discharge) begin c1++; @(negedge clk); end
      while (!discharge && !adc_req) begin c2++; @(negedge clk); end
      chk("R3 discharge cycles", c1, DIS);
      chk("R3 settle cycles", c2, SETTLE);
      chk("R3 request after settle", adc_req, 1);
      chk("R10 switch off during conversion", discharge, 0);
    end
    if (poke) begin
      while (discharge) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk({"R7/R8 code ", tag}, dt_code, ec);
    chk({"R6/R8 error ", tag}, ferr, ee);
    chk({"R5/R2 measurements ", tag}, idx, en);
    @(negedge clk);
    chk({"R9 done one cycle ", tag}, done, 0);
    chk({"R10 idle discharge ", tag}, discharge, 1);
    repeat (4) @(negedge clk);
    chk({"R9 code held ", tag}, dt_code, ec);
    chk({"R9 error held ", tag}, ferr, ee);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 discharge", discharge, 1);
    chk("R1 request", adc_req, 0);
    chk("R1 error", ferr, 0);
    chk("R1 code", dt_code, START);
    rst_n = 1'b1;
    @(negedge clk);

    // flat samples: no rise, floor reached (R8)
    for (int i = 0; i < 8; i++) samp[i] = 100;
    run("flat", 0, 1'b0, 1'b1);

    // sweep rise position and margin edge (R6, R7; k=4 is the floor collision)
    for (int k = 1; k <= 4; k++) begin
      for (int d = MARGIN; d <= MARGIN + 1; d++) begin
        for (int i = 0; i < 8; i++) samp[i] = 200 - 10 * i;
        samp[k] = samp[k-1] + d;
        run($sformatf("k%0d_d%0d", k, d), (k + d) % 3, (k == 2), 1'b0);
      end
    end

    // deep dip then moderate rise, rise judged against the minimum (R5)
    samp[0] = 200; samp[1] = 120; samp[2] = 150; samp[3] = 90;
    samp[4] = 80; samp[5] = 0; samp[6] = 0; samp[7] = 0;
    run("dip", 1, 1'b1, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule